// File: doc/BRIEF.md
# Two-Wire Serial Programming Host Engine

This block is the host end of a two-wire serial programming link. It generates the serial clock and drives or releases a shared data line. Each transaction sends a 6-bit command code, least significant bit first. It can then add one 16-slot data frame that either carries a 14-bit word to the target (load) or collects a 14-bit word from it (read). The bidirectional data pin is provided as three signals: an output value, an output enable and an input. The pad that joins them sits outside this block.

A user presents a command code, a transaction type and a write word, and pulses the start strobe. The engine shifts the command out and waits the turnaround gap if a data frame follows. It then runs the frame and waits the gap that the command requires before the next one can begin. The gaps are longer after the end-programming and bulk-erase codes. The serial half-period and every gap are parameters counted in system clock cycles. When the transaction completes, busy falls and done pulses for one cycle. For a read, the received word is presented on the read port at that point.

Top module: `sprog_host`

## Requirements
- R1: After reset the serial clock is low, the data line is driven (output enable 1) with value 0, and busy and done are 0; the serial clock stays low whenever busy is 0.
- R2: A command is exactly six serial clock pulses. Each pulse is HALF system cycles high followed by HALF cycles low, and pulse k carries bit k of the command code (bit 0 first), with the output enable at 1.
- R3: The data output changes only in the cycle in which the serial clock rises, so it is stable across every falling edge.
- R4: With type 1 (load), sixteen more pulses follow the command, with the output enable at 1. They carry 0 in the first slot, write-word bits 0 to 13 in slots 2 to 15, and 0 in the last slot.
- R5: With type 2 (read), the output enable is 0 from the end of the command through the whole 16-pulse frame. The line is sampled at the falling edges of slots 2 to 15 (bit 0 first), and that word appears on the read port when done pulses.
- R6: When a data frame follows, the serial clock stays low for exactly HALF + GAP_CD system cycles between the last command falling edge and the first frame rising edge.
- R7: After the final pulse of a transaction, the serial clock stays low for exactly HALF + G cycles before done pulses. G is GAP_END for code END_CODE, GAP_ERASE for code ERASE_CODE, and GAP_CMD for any other code.
- R8: Busy is 1 from the cycle after an accepted start until done. Done is a one-cycle pulse, and busy is 0 in that cycle. A start while busy is ignored.
- R9: Type 0 or type 3 sends the command alone, with no data frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a transaction (sampled when idle) |
| cmd_code | input | 6 | Command code, sent unchanged |
| cmd_kind | input | 2 | 0 none, 1 load, 2 read, 3 none |
| wr_word | input | 14 | Word sent in a load frame |
| rd_word | output | 14 | Word captured by the last read |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| pclk | output | 1 | Serial clock to the target |
| pdat_out | output | 1 | Data line value when driven |
| pdat_oe | output | 1 | Data line driver enable |
| pdat_in | input | 1 | Data line value seen at the pin |

## Verification
Every result is judged in the cycle of the done pulse. The serial clock starts rising in the cycle after the strobe. The turnaround gap must measure exactly HALF + GAP_CD low cycles, and the trailing gap exactly HALF + G low cycles ending in the cycle before done. A bench-side target model records the data line at each serial falling edge and drives read bits after each rising edge. The checks sample on the falling system-clock edge and compare the recorded waveform with the expected item popped from the queue, so a shift of one cycle in any gap or slot shows up as a mismatch.

// File: rtl/sprog_host.sv
module sprog_host #(
  parameter int HALF      = 5,
  parameter int GAP_CD    = 50,
  parameter int GAP_CMD   = 50,
  parameter int GAP_END   = 5000,
  parameter int GAP_ERASE = 300000,
  parameter logic [5:0] END_CODE   = 6'h0A,
  parameter logic [5:0] ERASE_CODE = 6'h09
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [5:0]  cmd_code,
  input  logic [1:0]  cmd_kind,
  input  logic [13:0] wr_word,
  output logic [13:0] rd_word,
  output logic        busy,
  output logic        done,
  output logic        pclk,
  output logic        pdat_out,
  output logic        pdat_oe,
  input  logic        pdat_in
);

  localparam int M1   = (GAP_CMD > GAP_END) ? GAP_CMD : GAP_END;
  localparam int M2   = (M1 > GAP_ERASE) ? M1 : GAP_ERASE;
  localparam int GMAX = (M2 > GAP_CD) ? M2 : GAP_CD;
  localparam int GW   = $clog2(GMAX + 1);
  localparam int HW   = $clog2(HALF + 1);
  localparam logic [1:0] K_LOAD = 2'd1;
  localparam logic [1:0] K_READ = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_GAP1, S_DATA, S_GAP2} st_t;

  st_t         st;
  logic [HW-1:0] hcnt;
  logic [GW-1:0] gcnt;
  logic [3:0]  bidx;
  logic [5:0]  code_q;
  logic [1:0]  kind_q;
  logic [15:0] frame_q, sh;
  logic [13:0] rd_sh, rd_q;
  logic        pclk_q, dat_q, oe_q, done_q;

  wire is_read  = (kind_q == K_READ);
  wire has_data = (kind_q == K_LOAD) || is_read;
  wire last_bit = (st == S_CMD) ? (bidx == 4'd5) : (bidx == 4'd15);
  wire [GW-1:0] post_gap = (code_q == END_CODE)   ? GW'(GAP_END - 1)   :
                           (code_q == ERASE_CODE) ? GW'(GAP_ERASE - 1) :
                                                    GW'(GAP_CMD - 1);

  assign busy     = (st != S_IDLE);
  assign done     = done_q;
  assign pclk     = pclk_q;
  assign pdat_out = dat_q;
  assign pdat_oe  = oe_q;
  assign rd_word  = rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      hcnt    <= '0;
      gcnt    <= '0;
      bidx    <= '0;
      code_q  <= '0;
      kind_q  <= '0;
      frame_q <= '0;
      sh      <= '0;
      rd_sh   <= '0;
      rd_q    <= '0;
      pclk_q  <= 1'b0;
      dat_q   <= 1'b0;
      oe_q    <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          code_q  <= cmd_code;
          kind_q  <= cmd_kind;
          frame_q <= {1'b0, wr_word, 1'b0};
          sh      <= {10'd0, cmd_code};
          dat_q   <= cmd_code[0];
          oe_q    <= 1'b1;
          pclk_q  <= 1'b1;
          hcnt    <= HW'(HALF - 1);
          bidx    <= '0;
          st      <= S_CMD;
        end
        S_CMD, S_DATA: begin
          if (hcnt != '0) begin
            hcnt <= hcnt - 1'b1;
          end else if (pclk_q) begin
            pclk_q <= 1'b0;
            hcnt   <= HW'(HALF - 1);
            if (st == S_DATA && is_read && bidx != 4'd0 && bidx != 4'd15)
              rd_sh <= {pdat_in, rd_sh[13:1]};
          end else if (last_bit) begin
            if (st == S_CMD && has_data) begin
              st   <= S_GAP1;
              gcnt <= GW'(GAP_CD - 1);
              if (is_read) oe_q <= 1'b0;
            end else begin
              st   <= S_GAP2;
              gcnt <= post_gap;
              oe_q <= 1'b1;
            end
          end else begin
            bidx   <= bidx + 1'b1;
            sh     <= sh >> 1;
            dat_q  <= sh[1];
            pclk_q <= 1'b1;
            hcnt   <= HW'(HALF - 1);
          end
        end
        S_GAP1: begin
          if (gcnt == '0) begin
            st     <= S_DATA;
            bidx   <= '0;
            sh     <= frame_q;
            dat_q  <= frame_q[0];
            pclk_q <= 1'b1;
            hcnt   <= HW'(HALF - 1);
          end else begin
            gcnt <= gcnt - 1'b1;
          end
        end
        S_GAP2: begin
          if (gcnt == '0) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
            if (is_read) rd_q <= rd_sh;
          end else begin
            gcnt <= gcnt - 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_pclk_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !pclk);
  assert_cmd_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CMD) |-> (bidx < 4'd6));
  assert_dat_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pdat_out) |-> $rose(pclk));
  assert_read_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_GAP1 || st == S_DATA) && is_read) |-> !pdat_oe);
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: tb/sprog_host_bench.sv
module sprog_host_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2, GAP_CD = 5, GAP_CMD = 3, GAP_END = 11, GAP_ERASE = 17;
  localparam logic [5:0] END_CODE = 6'h0A, ERASE_CODE = 6'h09;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, pdat_in = 1'b0;
  logic [5:0] cmd_code = '0;
  logic [1:0] cmd_kind = '0;
  logic [13:0] wr_word = '0, rd_word, tgt_word = '0;
  logic busy, done, pclk, pdat_out, pdat_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  sprog_host #(.HALF(HALF), .GAP_CD(GAP_CD), .GAP_CMD(GAP_CMD), .GAP_END(GAP_END),
    .GAP_ERASE(GAP_ERASE), .END_CODE(END_CODE), .ERASE_CODE(ERASE_CODE)) u_sprog_host (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_code(cmd_code), .cmd_kind(cmd_kind),
    .wr_word(wr_word), .rd_word(rd_word), .busy(busy), .done(done), .pclk(pclk),
    .pdat_out(pdat_out), .pdat_oe(pdat_oe), .pdat_in(pdat_in));

  typedef struct { logic [5:0] code; logic [1:0] kind; logic [13:0] word; logic [13:0] tgt; } exp_t;
  exp_t q[$];
  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // target model and monitor
  logic pclk_d = 1'b0, dat_d = 1'b0, busy_d = 1'b0;
  int rises = 0, falls = 0, lowrun = 0, gap_meas = -1, r3_bad = 0;
  logic [31:0] bits = '0, oes = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (pdat_out !== dat_d && !(pclk && !pclk_d)) r3_bad++;
      if (done) begin
        if (q.size() == 0) chk(0, "R8", "done without request", 1, 0);
        else begin
          exp_t e;
          int g, nf;
          logic [15:0] fr;
          bit dat, rd;
          e = q.pop_front();
          dat = (e.kind == 2'd1) || (e.kind == 2'd2);
          rd  = (e.kind == 2'd2);
          nf  = dat ? 22 : 6;
          g   = (e.code == END_CODE) ? GAP_END : (e.code == ERASE_CODE) ? GAP_ERASE : GAP_CMD;
          chk(falls == nf, dat ? "R4" : "R9", "pulse count", falls, nf);
          chk(bits[5:0] == e.code, "R2", "command bits", int'(bits[5:0]), int'(e.code));
          chk(oes[5:0] == 6'h3F, "R2", "command enable", int'(oes[5:0]), 63);
          if (dat) chk(gap_meas == HALF + GAP_CD, "R6", "turnaround low cycles", gap_meas, HALF + GAP_CD);
          if (e.kind == 2'd1) begin
            fr = {1'b0, e.word, 1'b0};
            chk(bits[21:6] == fr, "R4", "load frame", int'(bits[21:6]), int'(fr));
            chk(oes[21:6] == 16'hFFFF, "R4", "load enable", int'(oes[21:6]), 16'hFFFF);
          end
          if (rd) begin
            chk(oes[21:6] == 16'h0, "R5", "read enable", int'(oes[21:6]), 0);
            chk(rd_word == e.tgt, "R5", "read word", int'(rd_word), int'(e.tgt));
          end
          chk(lowrun == HALF + g, "R7", "trailing low cycles", lowrun, HALF + g);
          chk(!busy && busy_d, "R8", "busy around done", int'({busy_d, busy}), 2);
          chk(r3_bad == 0, "R3", "data change off rising edge", r3_bad, 0);
        end
        rises = 0; falls = 0; bits = '0; oes = '0; gap_meas = -1; r3_bad = 0;
      end
      if (pclk && !pclk_d) begin
        int d;
        rises++;
        if (rises == 7) gap_meas = lowrun;
        d = rises - 7;
        pdat_in = (d >= 1 && d <= 14) ? tgt_word[d-1] : 1'b0;
      end else if (!pclk && pclk_d) begin
        if (falls < 32) begin
          bits[falls] = pdat_out;
          oes[falls]  = pdat_oe;
        end
        falls++;
        lowrun = 1;
      end else if (!pclk) lowrun++;
    end
    pclk_d = pclk; dat_d = pdat_out; busy_d = busy;
  end

  task automatic run(input logic [5:0] c, input logic [1:0] k, input logic [13:0] w,
                     input logic [13:0] t, input bit poke);
    exp_t e;
    e.code = c; e.kind = k; e.word = w; e.tgt = t;
    q.push_back(e);
    tgt_word = t;
    @(negedge clk);
    cmd_code = c; cmd_kind = k; wr_word = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R8", "busy after start", int'(busy), 1);
    if (poke) begin
      repeat (10) @(negedge clk);
      cmd_code = ~c; cmd_kind = 2'd1; wr_word = ~w; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(!busy && !pclk, "R8", "idle after done", int'({busy, pclk}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "ALL", "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!pclk && pdat_oe && !pdat_out && !busy && !done, "R1", "reset state",
        int'({pclk, pdat_oe, pdat_out, busy, done}), 8);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run(6'h0A, 2'd0, 14'h0, 14'h0, 0);
    run(6'h09, 2'd0, 14'h0, 14'h0, 0);
    run(6'h02, 2'd1, 14'h2A5A, 14'h0, 0);
    run(6'h02, 2'd1, 14'h3FFF, 14'h0, 0);
    run(6'h04, 2'd2, 14'h0, 14'h1234, 0);
    run(6'h04, 2'd2, 14'h0, 14'h2AAB, 0);
    run(6'h06, 2'd3, 14'h1111, 14'h0, 0);
    run(6'h02, 2'd1, 14'h0001, 14'h0, 1);
    run(6'h08, 2'd0, 14'h0, 14'h0, 1);
    run(6'h3F, 2'd2, 14'h0, 14'h3FFE, 0);
    chk(q.size() == 0, "R8", "pending items", q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule